// File: doc/BRIEF.md
# SPI Register-Access Slave Front End

This block lets an external SPI master read and write a bank of byte-wide registers and byte FIFOs that sit behind it. Every access opens with chip select falling and a command byte on MOSI. The command byte names one register and says whether the bytes after it are written or read. While the command byte shifts in, the slave returns a status byte of interrupt-request bits on MISO. After that, data moves one byte per eight clocks for as long as chip select stays low. The target address never advances during such a burst, so the master can drain or fill a FIFO in one access, or touch the same register again and again.

SCK, chip select and MOSI are brought into the system clock domain through synchronizers and sampled there. Data is taken on the rising edge of SCK, so clock-idle-low and clock-idle-high masters (SPI modes 0 and 3) work the same way. A duplex control input sets the pin use. In full-duplex, read data leaves on MISO. In half-duplex, read data is driven back on the shared MOSI line through an output enable. The registers themselves are outside the block. A plain register port stands in for them: an address, a write strobe with its data, and a read-acknowledge strobe with a read-data input.

Top module: `spi_regport`

## Requirements
- R1: The first eight rising SCK edges after chip select goes low carry the command byte, MSB first. Bits 7:3 hold the register number and bit 1 is the direction (1 = write, 0 = read). A read access never raises the write strobe.
- R2: During the command byte, MISO carries, MSB first, the status input as it stood when chip select fell. Changes to the status input later in the access do not alter it.
- R3: In a write access, each complete data byte (MSB first) gives one single-cycle write strobe, with that byte on the write-data output and the command's register number on the address output.
- R4: In a read access, each data byte shifted out is the read-data input for the addressed register, MSB first. One read-acknowledge pulse follows each complete read byte, and the next byte is taken after it, so a FIFO is drained in order.
- R5: The address output holds the command's register number for the whole burst, for FIFO and non-FIFO registers alike.
- R6: Command bit 0, an acknowledge flag, has no effect: accesses with it set behave exactly as with it clear.
- R7: With the duplex input at 1, MISO carries read data and the MISO enable stays high for the whole access, while the MOSI output enable stays low.
- R8: With the duplex input at 0, the MISO enable is high only during the command byte. Read data is driven on the MOSI output with the MOSI enable high during the data bytes of a read. The MOSI enable stays low during writes.
- R9: Raising chip select discards a partial byte without any strobe and returns the slave to the command phase. Both output enables are low while chip select is high.
- R10: SCK idling low (mode 0) and idling high (mode 3) give identical results.
- R11: After reset both output enables and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| full_dup | input | 1 | 1 = separate MISO pin for read data, 0 = read data on the shared MOSI line |
| status | input | 8 | Interrupt-request bits returned during the command byte |
| sck | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| mosi_in | input | 1 | Master-to-slave data |
| mosi_out | output | 1 | Read data for the shared MOSI line in half-duplex |
| mosi_oe | output | 1 | Drive enable for the shared MOSI line |
| miso_out | output | 1 | Slave-to-master data |
| miso_oe | output | 1 | Drive enable for MISO |
| reg_addr | output | 5 | Register number of the current access |
| wr_en | output | 1 | Single-cycle write strobe |
| wr_data | output | 8 | Byte to write |
| rd_en | output | 1 | Single-cycle read acknowledge after each read byte |
| rd_data | input | 8 | Current content of the addressed register or FIFO head |

## Verification
A bit counter that slips by one turns every later byte of the access into a one-bit-shifted value. This shows in the next read byte the master samples and in the write data at the next strobe, within one SCK period. A phase flag that fails to leave or re-enter the command phase shows as the status byte repeated in the data slot, as a missing strobe, or as a drive enable on the wrong pin. Each of these is visible at the first sample of the following byte. An address that drifts during a burst appears on the address output at the next strobe, and a FIFO read out of order appears as a byte sequence that does not match the order in which it was written.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] regnum;
        logic              is_write;
    } cmd_t;

    // Register number sits in the top bits, direction in bit 1.
    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.regnum   = b[BYTE_W-1 -: ADDR_W];
        c.is_write = b[1];
        return c;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= RST_VAL;
                    else     stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    output logic              cs_act,
    output logic [CNT_W-1:0]  bit_idx,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sck_d;
    logic [BYTE_W-1:0] shreg;
    logic              rise;

    assign cs_act = ~cs_n_s;
    assign rise   = sck_s & ~sck_d & ~cs_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d     <= 1'b0;
            bit_idx   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            sck_d     <= sck_s;
            byte_done <= 1'b0;
            if (cs_n_s) begin
                bit_idx <= '0;
                shreg   <= '0;
            end else if (rise) begin
                shreg   <= {shreg[BYTE_W-2:0], mosi_s};
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx == LAST_BIT) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {shreg[BYTE_W-2:0], mosi_s};
                end
            end
        end
    end
endmodule

// File: rtl/spi_txn_ctl.sv
module spi_txn_ctl
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic [BYTE_W-1:0] status,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              full_dup,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en,
    output logic              line_bit,
    output logic              miso_oe,
    output logic              mosi_oe,
    output logic              data_phase,
    output logic              is_wr
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            phase;
    logic [BYTE_W-1:0] tx_byte;
    logic              load_p1, load_p2;
    cmd_t              cmd_w;

    assign cmd_w = decode_cmd(rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            reg_addr <= '0;
            is_wr    <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
            rd_en    <= 1'b0;
            tx_byte  <= '0;
            load_p1  <= 1'b0;
            load_p2  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            rd_en   <= 1'b0;
            load_p1 <= 1'b0;
            load_p2 <= load_p1;
            if (!cs_act) begin
                phase   <= PH_CMD;
                tx_byte <= status;
            end else if (byte_done) begin
                if (phase == PH_CMD) begin
                    reg_addr <= cmd_w.regnum;
                    is_wr    <= cmd_w.is_write;
                    phase    <= PH_DATA;
                    load_p1  <= ~cmd_w.is_write;
                end else if (is_wr) begin
                    wr_en   <= 1'b1;
                    wr_data <= rx_byte;
                end else begin
                    rd_en   <= 1'b1;
                    load_p1 <= 1'b1;
                end
            end
            if (cs_act && load_p2) tx_byte <= rd_data;
        end
    end

    assign data_phase = (phase == PH_DATA);
    assign line_bit   = tx_byte[LAST_BIT - bit_idx];
    assign miso_oe    = cs_act & (~data_phase | full_dup);
    assign mosi_oe    = cs_act & data_phase & ~is_wr & ~full_dup;
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full_dup,
    input  logic [BYTE_W-1:0] status,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en,
    input  logic [BYTE_W-1:0] rd_data
);
    logic [2:0]        pins_s;
    logic              cs_act, byte_done, line_bit, data_phase, is_wr;
    logic [CNT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] rx_byte;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sck, cs_n, mosi_in}),
        .dout(pins_s)
    );

    spi_bit_engine u_bits (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (pins_s[2]),
        .cs_n_s   (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .cs_act   (cs_act),
        .bit_idx  (bit_idx),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    spi_txn_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .bit_idx   (bit_idx),
        .status    (status),
        .rd_data   (rd_data),
        .full_dup  (full_dup),
        .reg_addr  (reg_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .line_bit  (line_bit),
        .miso_oe   (miso_oe),
        .mosi_oe   (mosi_oe),
        .data_phase(data_phase),
        .is_wr     (is_wr)
    );

    assign miso_out = line_bit;
    assign mosi_out = line_bit;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_regport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              data_phase,
    input logic              is_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              miso_oe,
    input logic              mosi_oe
);
    assert_single_driver_R8: assert property (@(posedge clk) disable iff (rst)
        !(miso_oe && mosi_oe));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cs_act && data_phase && $past(cs_act) && $past(data_phase)) |-> $stable(reg_addr));

    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_wr_dir_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (is_wr && data_phase));

    assert_rd_dir_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (!is_wr && data_phase));

    assert_strobe_needs_select_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rd_en) |-> $past(cs_act));

    assert_status_driven_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_act && !data_phase) |-> miso_oe);
endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .data_phase(data_phase),
    .is_wr     (is_wr),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .miso_oe   (miso_oe),
    .mosi_oe   (mosi_oe)
);

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
    import spi_regport_pkg::*;

    localparam int              H      = 6;
    localparam logic [4:0]      FIFO_A = 5'd3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, full_dup, sck, cs_n, mosi_in;
    logic [7:0] stat_in, rd_data, wr_data;
    logic       mosi_out, mosi_oe, miso_out, miso_oe, wr_en, rd_en;
    logic [4:0] reg_addr;

    spi_regport u_spi_regport (
        .clk(clk), .rst(rst), .full_dup(full_dup), .status(stat_in),
        .sck(sck), .cs_n(cs_n), .mosi_in(mosi_in),
        .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_out(miso_out), .miso_oe(miso_oe),
        .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic idle_hi;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Register bank served to the design, driven only by its strobes.
    logic [7:0]  srv_mem [32];
    logic [7:0]  srv_q [$];
    logic [12:0] wlog [$];
    int          rd_cnt = 0;

    // Reference model of what the bank should hold.
    logic [7:0]  mdl_mem [32];
    logic [7:0]  mdl_q [$];

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                wlog.push_back({reg_addr, wr_data});
                if (reg_addr == FIFO_A) srv_q.push_back(wr_data);
                else                    srv_mem[reg_addr] = wr_data;
            end
            if (rd_en) begin
                rd_cnt++;
                if (reg_addr == FIFO_A && srv_q.size() > 0) void'(srv_q.pop_front());
            end
        end
        if (reg_addr == FIFO_A) rd_data = (srv_q.size() > 0) ? srv_q[0] : 8'h00;
        else                    rd_data = srv_mem[reg_addr];
    end

    task automatic shift(input logic [7:0] ob, input int nb, output logic [7:0] ib,
                         output logic m_oe, output logic s_oe);
        ib = '0; m_oe = 0; s_oe = 0;
        for (int k = 7; k >= 8 - nb; k--) begin
            sck = 1'b0;
            mosi_in = ob[k];
            repeat (H) @(negedge clk);
            ib[k] = mosi_oe ? mosi_out : miso_out;
            if (k == 7) begin m_oe = miso_oe; s_oe = mosi_oe; end
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
    endtask

    task automatic begin_access(input logic [7:0] cmd);
        logic [7:0] st_exp, got;
        logic mo, so;
        st_exp = stat_in;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        stat_in = ~stat_in;  // later change must not reach the status byte
        shift(cmd, 8, got, mo, so);
        check("R2 status byte during command", got, st_exp);
        check("R2 miso_oe during command", mo, 1);
        check("R8 mosi_oe during command", so, 0);
    endtask

    task automatic end_access();
        if (!idle_hi) sck = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
        check("R9 miso_oe idle", miso_oe, 0);
        check("R9 mosi_oe idle", mosi_oe, 0);
    endtask

    task automatic do_write(input logic [4:0] addr, input int n, input logic ack,
                            input logic [7:0] first, input logic [7:0] step);
        logic [7:0] got, b;
        logic mo, so;
        check("R3 write log empty before", wlog.size(), 0);
        begin_access({addr, 1'b0, 1'b1, ack});
        for (int i = 0; i < n; i++) begin
            b = first + 8'(i) * step;
            shift(b, 8, got, mo, so);
            check("R7/R8 miso_oe in write data", mo, full_dup);
            check("R8 mosi_oe in write data", so, 0);
            if (addr == FIFO_A) mdl_q.push_back(b);
            else                mdl_mem[addr] = b;
            if (i > 0) begin
                check("R3 write strobe address", wlog[i-1][12:8], addr);
                check("R3 write strobe data", wlog[i-1][7:0], 8'(first + 8'(i - 1) * step));
            end
        end
        end_access();
        check("R3 write strobe count", wlog.size(), n);
        for (int i = 0; i < n && wlog.size() > 0; i++) begin
            logic [12:0] e;
            e = wlog.pop_front();
            check("R5 address fixed in write burst", e[12:8], addr);
            check("R3 write data order", e[7:0], 8'(first + 8'(i) * step));
        end
    endtask

    task automatic do_read(input logic [4:0] addr, input int n, input logic ack);
        logic [7:0] got, exp;
        logic mo, so;
        int rc0;
        rc0 = rd_cnt;
        begin_access({addr, 1'b0, 1'b0, ack});
        for (int i = 0; i < n; i++) begin
            if (addr == FIFO_A) exp = (mdl_q.size() > 0) ? mdl_q.pop_front() : 8'h00;
            else                exp = mdl_mem[addr];
            shift(8'h00, 8, got, mo, so);
            check("R4 read byte", got, exp);
            check("R5 address held during read", reg_addr, addr);
            if (full_dup) begin
                check("R7 miso_oe in read data", mo, 1);
                check("R7 mosi_oe in read data", so, 0);
            end else begin
                check("R8 miso_oe in read data", mo, 0);
                check("R8 mosi_oe in read data", so, 1);
            end
        end
        end_access();
        check("R4 read acknowledge count", rd_cnt - rc0, n);
        check("R1 no write strobe on read", wlog.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] got;
        logic mo, so;
        for (int i = 0; i < 32; i++) begin
            srv_mem[i] = 8'(i * 7 + 1);
            mdl_mem[i] = 8'(i * 7 + 1);
        end
        rd_data = '0;
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; mosi_in = 1'b0;
        stat_in = 8'hA5; full_dup = 1'b1; idle_hi = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 miso_oe after reset", miso_oe, 0);
        check("R11 mosi_oe after reset", mosi_oe, 0);
        check("R11 wr_en after reset", wr_en, 0);
        check("R11 rd_en after reset", rd_en, 0);

        // Mode 0, full duplex: register burst write then read back (R1 R3 R4 R5 R7)
        do_write(5'd5, 3, 1'b0, 8'h3C, 8'h11);
        stat_in = 8'h5A;
        do_read(5'd5, 2, 1'b0);
        do_read(5'd17, 1, 1'b0);

        // Mode 3, half duplex: FIFO fill and drain (R4 R8 R10)
        idle_hi = 1'b1; sck = 1'b1; full_dup = 1'b0;
        repeat (H) @(negedge clk);
        stat_in = 8'hC3;
        do_write(FIFO_A, 4, 1'b0, 8'h81, 8'h13);
        do_read(FIFO_A, 4, 1'b0);

        // Acknowledge flag set has no effect (R6)
        do_write(5'd7, 2, 1'b1, 8'hE0, 8'h01);
        do_read(5'd7, 1, 1'b1);

        // Mode 3 full duplex read (R10)
        full_dup = 1'b1;
        do_read(5'd5, 1, 1'b0);

        // Back to mode 0
        idle_hi = 1'b0; sck = 1'b0;
        repeat (H) @(negedge clk);

        // Abort inside a write data byte (R9)
        begin_access({5'd9, 1'b0, 1'b1, 1'b0});
        shift(8'hF0, 4, got, mo, so);
        end_access();
        check("R9 partial byte gives no write", wlog.size(), 0);
        do_read(5'd9, 1, 1'b0);

        // Abort inside the command byte, next access decodes cleanly (R9 R1)
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        shift(8'hFF, 3, got, mo, so);
        end_access();
        do_write(5'd12, 1, 1'b0, 8'h6B, 8'h00);
        full_dup = 1'b0;
        do_read(5'd12, 2, 1'b0);

        done = 1;
        report();
    end
endmodule